// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a CAN frame that the receiver has just assembled is kept or dropped. The frame is presented as a descriptor: identifier, extended-format flag, remote-request flag, data length code and the first two data bytes. A single-cycle `frame_valid_i` pulse marks it. One clock later the block raises `done_o`, and `accept_o` carries the verdict in the same cycle.

The verdict comes from eight acceptance bytes. Bytes 0 to 3 hold code values and bytes 4 to 7 hold masks. A second, reduced pair (one code byte and one mask byte) serves the basic controller mode. In extended controller mode the eight bytes are interpreted in one of two layouts:

- **Single layout:** one wide filter. For standard frames it also screens the first two data bytes.
- **Dual layout:** two narrower filters, and a frame passes if either one matches.

All filter settings are captured when the controller leaves its reset mode. Software changes made while the controller is operating do not alter filtering until the next reset-to-operation transition.

Top module: `can_accept_filter`

## Requirements
- R1: `done_o` is high exactly in the cycle after each `frame_valid_i` pulse and low otherwise. `accept_o` is never high without `done_o`. Both outputs are 0 while `rst_ni` is low.
- R2: Every compared bit is governed by its mask bit. A mask bit of 1 makes the position don't-care. A mask bit of 0 requires the frame bit to equal the code bit.
- R3: In single layout with an extended frame, the frame matches when the 30-bit value {ID[28:0], RTR} equals {byte0, byte1, byte2, byte3[7:2]} under the mask {byte4, byte5, byte6, byte7[7:2]}. Byte k occupies `acc_bytes_i[8k+7:8k]`.
- R4: In single layout with a standard frame, the identifier check compares {ID[10:0], RTR} against {byte0, byte1[7:4]} under the mask {byte4, byte5[7:4]}. Data byte 0 is compared with byte2 under byte6, and data byte 1 with byte3 under byte7.
- R5: In single layout with a standard frame whose identifier matches, the frame is accepted without any data comparison when RTR is set or DLC is 0. When DLC is 1, only data byte 0 is compared. For a DLC of 2 or more, both data bytes are compared.
- R6: In dual layout with an extended frame, lane A compares ID[28:13] with {byte0, byte1} under {byte4, byte5`}`, and lane B compares it with {byte2, byte3} under {byte6, byte7}. ID[12:0] and RTR are ignored, and the frame is accepted if either lane matches.
- R7: In dual layout with a standard frame, lane A requires two matches:
  - {ID[10:0], RTR} against {byte0, byte1[7:4]} under {byte4, byte5[7:4]};
  - data byte 0 against {byte1[3:0], byte3[3:0]} under {byte5[3:0], byte7[3:0]}.
  
  Lane B compares {ID[10:0], RTR} against {byte2, byte3[7:4]} under {byte6, byte7[7:4]}. The frame is accepted if either lane matches.
- R8: When `ext_mode_i` is 0 (basic controller mode), the block compares only ID[10:3] with the basic code byte under the basic mask byte, and it always rejects extended frames.
- R9: A frame presented while `reset_mode_i` is 1 is rejected. Its `done_o` still pulses.
- R10: Acceptance bytes, basic code and mask, and `single_mode_i` are captured on the first clock edge at which `reset_mode_i` is 0 after having been 1. Changes made after that edge are ignored. A frame validated on that same edge is judged with the settings captured previously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_mode_i | input | 1 | 1 = controller in reset (configuration) mode |
| ext_mode_i | input | 1 | 1 = extended controller mode, 0 = basic mode |
| single_mode_i | input | 1 | 1 = single-filter layout, 0 = dual-filter layout |
| acc_bytes_i | input | 64 | Acceptance bytes; byte k at bits 8k+7:8k, bytes 0-3 code, 4-7 mask |
| basic_code_i | input | 8 | Basic-mode code byte for ID[10:3] |
| basic_mask_i | input | 8 | Basic-mode mask byte (1 = don't care) |
| frame_valid_i | input | 1 | One-cycle pulse: frame descriptor valid |
| frame_id_i | input | 29 | Identifier; standard frames use bits 10:0 |
| frame_ext_i | input | 1 | 1 = extended-format frame |
| frame_rtr_i | input | 1 | 1 = remote request frame |
| frame_dlc_i | input | 4 | Data length code |
| frame_d0_i | input | 8 | Data byte 0 |
| frame_d1_i | input | 8 | Data byte 1 |
| done_o | output | 1 | Decision strobe, one cycle after `frame_valid_i` |
| accept_o | output | 1 | Frame accepted (valid with `done_o`) |

## Verification
A frame can be validated on the very edge at which the controller leaves reset mode. On that edge the new filter settings are captured and a decision is taken at once, so the two events collide. The bench provokes this case by holding one configuration, then entering reset mode with different bytes and releasing reset mode in the same cycle as a `frame_valid_i` pulse. The identifier is chosen to match only the old settings. The decision must follow the old settings, and the next frames must follow the new ones.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_ACC  = 8;
  localparam int unsigned EXT_ID_W = 29;
  localparam int unsigned STD_ID_W = 11;
  localparam int unsigned DLC_W    = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [NUM_ACC-1:0] acc_arr_t;

  typedef struct packed {
    acc_arr_t acc;
    byte_t    bcode;
    byte_t    bmask;
    logic     single;
  } flt_cfg_t;
endpackage

// File: rtl/can_flt_cfg.sv
module can_flt_cfg
  import can_flt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     reset_mode_i,
  input  flt_cfg_t cfg_i,
  output flt_cfg_t cfg_o,
  output logic     in_reset_o
);
  // snapshot taken on the reset->operation edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o      <= '0;
      in_reset_o <= 1'b1;
    end else begin
      in_reset_o <= reset_mode_i;
      if (in_reset_o && !reset_mode_i) cfg_o <= cfg_i;
    end
  end
endmodule

// File: rtl/can_flt_single.sv
module can_flt_single
  import can_flt_pkg::*;
(
  input  acc_arr_t            acc_i,
  input  logic [EXT_ID_W-1:0] id_i,
  input  logic                ext_i,
  input  logic                rtr_i,
  input  logic [DLC_W-1:0]    dlc_i,
  input  byte_t               d0_i,
  input  byte_t               d1_i,
  output logic                hit_o
);
  localparam int unsigned XLOW_W  = EXT_ID_W - 3*BYTE_W;
  localparam int unsigned SLOW_W  = STD_ID_W - BYTE_W;
  localparam int unsigned MSK_OFS = NUM_ACC/2;

  logic [EXT_ID_W:0] x_code, x_dc, x_val;
  logic [STD_ID_W:0] s_code, s_dc, s_val;
  logic x_ok, s_ok, d0_ok, d1_ok, s_hit;
  logic unused_bits;

  assign x_code = {acc_i[0], acc_i[1], acc_i[2], acc_i[3][BYTE_W-1 -: XLOW_W+1]};
  assign x_dc   = {acc_i[MSK_OFS], acc_i[MSK_OFS+1], acc_i[MSK_OFS+2],
                   acc_i[MSK_OFS+3][BYTE_W-1 -: XLOW_W+1]};
  assign x_val  = {id_i, rtr_i};
  assign x_ok   = ~|((x_val ^ x_code) & ~x_dc);

  assign s_code = {acc_i[0], acc_i[1][BYTE_W-1 -: SLOW_W+1]};
  assign s_dc   = {acc_i[MSK_OFS], acc_i[MSK_OFS+1][BYTE_W-1 -: SLOW_W+1]};
  assign s_val  = {id_i[STD_ID_W-1:0], rtr_i};
  assign s_ok   = ~|((s_val ^ s_code) & ~s_dc);

  assign d0_ok  = ~|((d0_i ^ acc_i[2]) & ~acc_i[MSK_OFS+2]);
  assign d1_ok  = ~|((d1_i ^ acc_i[3]) & ~acc_i[MSK_OFS+3]);

  // remote frames and empty frames skip the data screen
  assign s_hit  = s_ok && (rtr_i || (dlc_i == '0) ||
                  (d0_ok && ((dlc_i == DLC_W'(1)) || d1_ok)));

  assign hit_o  = ext_i ? x_ok : s_hit;

  assign unused_bits = ^{acc_i[3][BYTE_W-XLOW_W-2:0], acc_i[MSK_OFS+3][BYTE_W-XLOW_W-2:0]};
endmodule

// File: rtl/can_flt_dual_lane.sv
module can_flt_dual_lane
  import can_flt_pkg::*;
(
  input  logic [2*BYTE_W-1:0] code_i,
  input  logic [2*BYTE_W-1:0] dc_i,
  input  logic [2*BYTE_W-1:0] ext_id_i,
  input  logic [STD_ID_W-1:0] std_id_i,
  input  logic                rtr_i,
  output logic                ext_hit_o,
  output logic                std_hit_o
);
  localparam int unsigned PAIR_W = 2*BYTE_W;

  logic [STD_ID_W:0] s_val;

  assign ext_hit_o = ~|((ext_id_i ^ code_i) & ~dc_i);

  assign s_val     = {std_id_i, rtr_i};
  assign std_hit_o = ~|((s_val ^ code_i[PAIR_W-1 -: STD_ID_W+1]) &
                        ~dc_i[PAIR_W-1 -: STD_ID_W+1]);
endmodule

// File: rtl/can_flt_basic.sv
module can_flt_basic
  import can_flt_pkg::*;
(
  input  byte_t code_i,
  input  byte_t mask_i,
  input  byte_t id_hi_i,
  input  logic  ext_i,
  output logic  hit_o
);
  assign hit_o = !ext_i && ~|((id_hi_i ^ code_i) & ~mask_i);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reset_mode_i,
  input  logic                      ext_mode_i,
  input  logic                      single_mode_i,
  input  logic [NUM_ACC*BYTE_W-1:0] acc_bytes_i,
  input  logic [BYTE_W-1:0]         basic_code_i,
  input  logic [BYTE_W-1:0]         basic_mask_i,
  input  logic                      frame_valid_i,
  input  logic [EXT_ID_W-1:0]       frame_id_i,
  input  logic                      frame_ext_i,
  input  logic                      frame_rtr_i,
  input  logic [DLC_W-1:0]          frame_dlc_i,
  input  logic [BYTE_W-1:0]         frame_d0_i,
  input  logic [BYTE_W-1:0]         frame_d1_i,
  output logic                      done_o,
  output logic                      accept_o
);
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned MSK_OFS   = NUM_ACC/2;
  localparam int unsigned NIB_W     = BYTE_W/2;

  flt_cfg_t cfg_d, cfg_q;
  logic     in_reset_q;
  logic     single_hit, dual_hit, basic_hit, hit;
  logic [NUM_LANES-1:0] lane_ext, lane_std;
  byte_t    d0_exp, d0_dc;
  logic     d0_ok;
  logic     done_q, accept_q;

  assign cfg_d.acc    = acc_bytes_i;
  assign cfg_d.bcode  = basic_code_i;
  assign cfg_d.bmask  = basic_mask_i;
  assign cfg_d.single = single_mode_i;

  can_flt_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reset_mode_i(reset_mode_i),
    .cfg_i       (cfg_d),
    .cfg_o       (cfg_q),
    .in_reset_o  (in_reset_q)
  );

  can_flt_single u_single (
    .acc_i(cfg_q.acc),
    .id_i (frame_id_i),
    .ext_i(frame_ext_i),
    .rtr_i(frame_rtr_i),
    .dlc_i(frame_dlc_i),
    .d0_i (frame_d0_i),
    .d1_i (frame_d1_i),
    .hit_o(single_hit)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    can_flt_dual_lane u_lane (
      .code_i   ({cfg_q.acc[2*g], cfg_q.acc[2*g+1]}),
      .dc_i     ({cfg_q.acc[MSK_OFS+2*g], cfg_q.acc[MSK_OFS+2*g+1]}),
      .ext_id_i (frame_id_i[EXT_ID_W-1 -: 2*BYTE_W]),
      .std_id_i (frame_id_i[STD_ID_W-1:0]),
      .rtr_i    (frame_rtr_i),
      .ext_hit_o(lane_ext[g]),
      .std_hit_o(lane_std[g])
    );
  end

  // lane A data screen uses the spare nibbles of bytes 1/3 and 5/7
  assign d0_exp   = {cfg_q.acc[1][NIB_W-1:0], cfg_q.acc[3][NIB_W-1:0]};
  assign d0_dc    = {cfg_q.acc[MSK_OFS+1][NIB_W-1:0], cfg_q.acc[MSK_OFS+3][NIB_W-1:0]};
  assign d0_ok    = ~|((frame_d0_i ^ d0_exp) & ~d0_dc);
  assign dual_hit = frame_ext_i ? |lane_ext : ((lane_std[0] & d0_ok) | lane_std[1]);

  can_flt_basic u_basic (
    .code_i (cfg_q.bcode),
    .mask_i (cfg_q.bmask),
    .id_hi_i(frame_id_i[STD_ID_W-1 -: BYTE_W]),
    .ext_i  (frame_ext_i),
    .hit_o  (basic_hit)
  );

  assign hit = !reset_mode_i &&
               (ext_mode_i ? (cfg_q.single ? single_hit : dual_hit) : basic_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q   <= frame_valid_i;
      accept_q <= frame_valid_i && hit;
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
  import can_flt_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     frame_valid_i,
  input logic     reset_mode_i,
  input logic     ext_mode_i,
  input logic     frame_ext_i,
  input logic     done_o,
  input logic     accept_o,
  input logic     in_reset_q,
  input flt_cfg_t cfg_q
);
  // R1
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> done_o);
  // R1
  done_only_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !done_o);
  // R1
  accept_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> done_o);
  // R8
  basic_ext_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !ext_mode_i && frame_ext_i) |=> !accept_o);
  // R9
  reset_mode_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && reset_mode_i) |=> !accept_o);
  // R10
  cfg_hold_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_mode_i && !in_reset_q) |=> $stable(cfg_q));
  // R10
  cfg_hold_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mode_i |=> $stable(cfg_q));
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_valid_i(frame_valid_i),
  .reset_mode_i (reset_mode_i),
  .ext_mode_i   (ext_mode_i),
  .frame_ext_i  (frame_ext_i),
  .done_o       (done_o),
  .accept_o     (accept_o),
  .in_reset_q   (in_reset_q),
  .cfg_q        (cfg_q)
);

// File: tb/can_accept_filter_tb_top.sv
`timescale 1ns/1ps
module can_accept_filter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reset_mode_i = 1'b1;
  logic        ext_mode_i = 1'b1;
  logic        single_mode_i = 1'b1;
  logic [63:0] acc_bytes_i = '0;
  logic [7:0]  basic_code_i = '0;
  logic [7:0]  basic_mask_i = '0;
  logic        frame_valid_i = 1'b0;
  logic [28:0] frame_id_i = '0;
  logic        frame_ext_i = 1'b0;
  logic        frame_rtr_i = 1'b0;
  logic [3:0]  frame_dlc_i = '0;
  logic [7:0]  frame_d0_i = '0;
  logic [7:0]  frame_d1_i = '0;
  logic        done_o, accept_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] m_acc = '0;
  logic [7:0]  m_bc = '0, m_bm = '0;
  bit          m_single = 0;

  always #2.5 clk_i = ~clk_i;

  can_accept_filter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reset_mode_i(reset_mode_i),
    .ext_mode_i(ext_mode_i), .single_mode_i(single_mode_i),
    .acc_bytes_i(acc_bytes_i), .basic_code_i(basic_code_i), .basic_mask_i(basic_mask_i),
    .frame_valid_i(frame_valid_i), .frame_id_i(frame_id_i), .frame_ext_i(frame_ext_i),
    .frame_rtr_i(frame_rtr_i), .frame_dlc_i(frame_dlc_i), .frame_d0_i(frame_d0_i),
    .frame_d1_i(frame_d1_i), .done_o(done_o), .accept_o(accept_o)
  );

  function automatic logic [63:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic bit m_eq(input logic [31:0] v, c, dc, input int w);
    for (int i = 0; i < w; i++)
      if (!dc[i] && (v[i] !== c[i])) return 0;
    return 1;
  endfunction

  function automatic bit ref_accept(input logic [63:0] acc, input logic [7:0] bc, bm,
                                    input bit single, extm, inrst,
                                    input logic [28:0] id, input bit ext, rtr,
                                    input logic [3:0] dlc, input logic [7:0] d0, d1);
    logic [7:0] b [8];
    for (int k = 0; k < 8; k++) b[k] = acc[8*k +: 8];
    if (inrst) return 0;
    if (!extm) return !ext && m_eq(32'(id[10:3]), 32'(bc), 32'(bm), 8);
    if (single) begin
      if (ext) return m_eq(32'({id, rtr}), 32'({b[0], b[1], b[2], b[3][7:2]}),
                           32'({b[4], b[5], b[6], b[7][7:2]}), 30);
      if (!m_eq(32'({id[10:0], rtr}), 32'({b[0], b[1][7:4]}), 32'({b[4], b[5][7:4]}), 12))
        return 0;
      if (rtr || dlc == 0) return 1;
      if (!m_eq(32'(d0), 32'(b[2]), 32'(b[6]), 8)) return 0;
      if (dlc == 1) return 1;
      return m_eq(32'(d1), 32'(b[3]), 32'(b[7]), 8);
    end
    if (ext) return m_eq(32'(id[28:13]), 32'({b[0], b[1]}), 32'({b[4], b[5]}), 16) ||
                    m_eq(32'(id[28:13]), 32'({b[2], b[3]}), 32'({b[6], b[7]}), 16);
    if (m_eq(32'({id[10:0], rtr}), 32'({b[0], b[1][7:4]}), 32'({b[4], b[5][7:4]}), 12) &&
        m_eq(32'(d0), 32'({b[1][3:0], b[3][3:0]}), 32'({b[5][3:0], b[7][3:0]}), 8))
      return 1;
    return m_eq(32'({id[10:0], rtr}), 32'({b[2], b[3][7:4]}), 32'({b[6], b[7][7:4]}), 12);
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic configure(input logic [63:0] acc, input logic [7:0] bc, bm, input bit single);
    @(negedge clk_i);
    reset_mode_i = 1'b1; acc_bytes_i = acc; basic_code_i = bc; basic_mask_i = bm;
    single_mode_i = single;
    @(negedge clk_i);
    reset_mode_i = 1'b0;
    @(negedge clk_i);
    m_acc = acc; m_bc = bc; m_bm = bm; m_single = single;
  endtask

  task automatic send(input logic [28:0] id, input bit ext, rtr, input logic [3:0] dlc,
                      input logic [7:0] d0, d1, input bit exp, input string req);
    frame_id_i = id; frame_ext_i = ext; frame_rtr_i = rtr; frame_dlc_i = dlc;
    frame_d0_i = d0; frame_d1_i = d1; frame_valid_i = 1'b1;
    @(negedge clk_i);
    frame_valid_i = 1'b0;
    check(done_o, 1'b1, "R1", "done strobe");
    check(accept_o, exp, req, $sformatf("id %h ext %0b rtr %0b dlc %0d", id, ext, rtr, dlc));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(done_o, 1'b0, "R1", "done in reset");
    check(accept_o, 1'b0, "R1", "accept in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(done_o, 1'b0, "R1", "done idle");
  endtask

  task automatic t_single_ext();
    logic [28:0] e = 29'h1ABCDE5;
    ext_mode_i = 1'b1;
    configure(mk(e[28:21], e[20:13], e[12:5], {e[4:0], 3'b000},
                 8'h00, 8'h00, 8'h00, 8'h03), 8'h00, 8'h00, 1'b1);
    send(e, 1, 0, 4'd8, 8'h11, 8'h22, 1, "R3");
    send(e ^ 29'h1, 1, 0, 4'd8, 8'h11, 8'h22, 0, "R3");
    send(e, 1, 1, 4'd0, 8'h00, 8'h00, 0, "R3");
    send(e ^ 29'h10000000, 1, 0, 4'd2, 8'h00, 8'h00, 0, "R3");
    configure(mk(e[28:21], e[20:13], e[12:5], {e[4:0], 3'b000},
                 8'h00, 8'h00, 8'h00, 8'h0B), 8'h00, 8'h00, 1'b1);
    send(e ^ 29'h1, 1, 0, 4'd8, 8'h11, 8'h22, 1, "R2");
  endtask

  task automatic t_single_std();
    logic [10:0] s = 11'h5A3;
    configure(mk(s[10:3], {s[2:0], 5'b00000}, 8'hC3, 8'h3C,
                 8'h00, 8'h1F, 8'h00, 8'h00), 8'h00, 8'h00, 1'b1);
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R5");
    send(29'(s), 0, 1, 4'd8, 8'h00, 8'h00, 1, "R5");
    send(29'(s), 0, 0, 4'd1, 8'hC3, 8'h00, 1, "R5");
    send(29'(s), 0, 0, 4'd1, 8'hC2, 8'h3C, 0, "R5");
    send(29'(s), 0, 0, 4'd2, 8'hC3, 8'h3D, 0, "R4");
    send(29'(s), 0, 0, 4'd8, 8'hC3, 8'h3C, 1, "R4");
    send(29'(s ^ 11'h004), 0, 0, 4'd0, 8'h00, 8'h00, 0, "R4");
    configure(mk(s[10:3], {s[2:0], 5'b00000}, 8'hC3, 8'h3C,
                 8'h00, 8'h0F, 8'hF0, 8'h00), 8'h00, 8'h00, 1'b1);
    send(29'(s), 0, 0, 4'd1, 8'h33, 8'h00, 1, "R2");
    send(29'(s), 0, 1, 4'd0, 8'h00, 8'h00, 0, "R4");
  endtask

  task automatic t_dual_ext();
    configure(mk(8'hA5, 8'h5A, 8'h3C, 8'h96, 8'h00, 8'h00, 8'h00, 8'h00),
              8'h00, 8'h00, 1'b0);
    send({16'hA55A, 13'h1F0F}, 1, 0, 4'd0, 8'h00, 8'h00, 1, "R6");
    send({16'hA55A, 13'h0000}, 1, 1, 4'd3, 8'h00, 8'h00, 1, "R6");
    send({16'h3C96, 13'h0ABC}, 1, 0, 4'd8, 8'h00, 8'h00, 1, "R6");
    send({16'hA55B, 13'h1F0F}, 1, 0, 4'd0, 8'h00, 8'h00, 0, "R6");
  endtask

  task automatic t_dual_std();
    logic [10:0] s1 = 11'h2B6;
    logic [10:0] s2 = 11'h7E1;
    configure(mk(s1[10:3], {s1[2:0], 1'b0, 4'h9}, s2[10:3], {s2[2:0], 1'b0, 4'h4},
                 8'h00, 8'h00, 8'h00, 8'h00), 8'h00, 8'h00, 1'b0);
    send(29'(s1), 0, 0, 4'd1, 8'h94, 8'h00, 1, "R7");
    send(29'(s1), 0, 0, 4'd1, 8'h95, 8'h00, 0, "R7");
    send(29'(s2), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R7");
    send(29'(s1), 0, 1, 4'd1, 8'h94, 8'h00, 0, "R7");
    send(29'(s1 ^ 11'h001), 0, 0, 4'd1, 8'h94, 8'h00, 0, "R7");
  endtask

  task automatic t_basic();
    logic [10:0] s = 11'h5A3;
    ext_mode_i = 1'b0;
    configure(64'h0, s[10:3], 8'h00, 1'b1);
    send(29'(s), 0, 0, 4'd2, 8'h00, 8'h00, 1, "R8");
    send(29'(s ^ 11'h007), 0, 1, 4'd0, 8'h00, 8'h00, 1, "R8");
    send(29'(s ^ 11'h008), 0, 0, 4'd2, 8'h00, 8'h00, 0, "R8");
    send(29'(s), 1, 0, 4'd2, 8'h00, 8'h00, 0, "R8");
    configure(64'h0, s[10:3], 8'h01, 1'b1);
    send(29'(s ^ 11'h008), 0, 0, 4'd2, 8'h00, 8'h00, 1, "R8");
    ext_mode_i = 1'b1;
  endtask

  task automatic t_reset_mode();
    logic [10:0] s = 11'h5A3;
    configure(mk(s[10:3], {s[2:0], 5'b00000}, 8'h00, 8'h00,
                 8'h00, 8'h1F, 8'hFF, 8'hFF), 8'h00, 8'h00, 1'b1);
    reset_mode_i = 1'b1;
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 0, "R9");
    @(negedge clk_i);
    check(done_o, 1'b0, "R1", "done after single pulse");
    reset_mode_i = 1'b0;
    @(negedge clk_i);
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R9");
  endtask

  task automatic t_cfg_hold();
    logic [10:0] s = 11'h5A3;
    logic [10:0] t = 11'h123;
    configure(mk(s[10:3], {s[2:0], 5'b00000}, 8'h00, 8'h00,
                 8'h00, 8'h1F, 8'hFF, 8'hFF), 8'h00, 8'h00, 1'b1);
    acc_bytes_i = 64'h0;
    single_mode_i = 1'b0;
    @(negedge clk_i);
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R10");
    reset_mode_i = 1'b1;
    acc_bytes_i = mk(t[10:3], {t[2:0], 5'b00000}, 8'h00, 8'h00,
                     8'h00, 8'h1F, 8'hFF, 8'hFF);
    single_mode_i = 1'b1;
    @(negedge clk_i);
    reset_mode_i = 1'b0;
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R10");
    send(29'(s), 0, 0, 4'd0, 8'h00, 8'h00, 0, "R10");
    send(29'(t), 0, 0, 4'd0, 8'h00, 8'h00, 1, "R10");
  endtask

  task automatic t_random();
    for (int i = 0; i < 240; i++) begin
      if (i % 8 == 0) begin
        ext_mode_i = 1'($urandom_range(0, 3) != 0);
        configure({$urandom | $urandom | $urandom, $urandom},
                  8'($urandom), 8'($urandom | $urandom), 1'($urandom));
      end
      begin
        logic [28:0] id = 29'($urandom);
        bit ext = 1'($urandom);
        bit rtr = 1'($urandom);
        logic [3:0] dlc = 4'($urandom_range(0, 8));
        logic [7:0] d0 = 8'($urandom);
        logic [7:0] d1 = 8'($urandom);
        if (!ext) id = {18'h0, id[10:0]};
        send(id, ext, rtr, dlc, d0, d1,
             ref_accept(m_acc, m_bc, m_bm, m_single, ext_mode_i, 0, id, ext, rtr, dlc, d0, d1),
             "R2");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_single_ext();
    t_single_std();
    t_dual_ext();
    t_dual_std();
    t_basic();
    t_reset_mode();
    t_cfg_hold();
    t_random();
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule